// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits between a memory controller and the DRAM devices of a registered memory module. On each rising clock edge it captures the address, bank address, row/column/write command strobes, chip selects, clock enables and on-die-termination controls. It re-drives them to two identical output copies, one for each side of the module. The command and address fields move to the outputs only when exactly one chip select is asserted. Otherwise those outputs keep their last values. The chip-select, clock-enable and termination outputs follow their inputs every cycle.

The controller supplies one parity bit per command. The block checks even parity over the fields that every rank shares: the address, the bank address and the three command strobes. On a mismatch it pulls an active-low error line low for two clocks.

A static strap sets the chip-select mode. With the strap high, the block uses two selects, and each select drives an A-side output and a B-side output. With the strap low, four independent selects pass one-to-one to four outputs.

Top module: `cmd_reg_parity`

## Requirements
- R1: While `rst_n` is low, the outputs take these values at once, without waiting for a clock:
  - `cs_out_n` = 4'hF
  - `cke_a`, `cke_b`, `odt_a`, `odt_b` = 0
  - address and bank outputs = 0
  - the three command strobe outputs = 1
  - `err_n` = 1 (released)
- R2: When exactly one chip select of the active set is low at a rising edge, both output copies of address, bank and the three strobes (`ras`, `cas`, `we`) show the captured values after that edge.
- R3: When none or more than one of the active chip selects are low at a rising edge, the address, bank and strobe outputs keep their previous values.
- R4: With `quad_n`=1 (dual mode), the active set is `cs_n_in[1:0]`. After each edge, `cs_out_n[1:0]` (A side) and `cs_out_n[3:2]` (B side) both equal the captured `cs_n_in[1:0]`. `cs_n_in[3:2]` affects neither the outputs nor the select decision.
- R5: With `quad_n`=0 (quad mode), the active set is `cs_n_in[3:0]`, and after each edge `cs_out_n[i]` equals the captured `cs_n_in[i]`.
- R6: `cke_in` and `odt_in` are registered to both copies every cycle, whatever the chip selects are.
- R7: Parity is even. If the count of ones in address, bank, `ras_n_in`, `cas_n_in`, `we_n_in` and `par_in` is odd in a cycle that captures a command, `err_n` goes low one edge later and stays low for two clocks.
- R8: Chip selects, clock enables and termination inputs do not enter the parity sum. A command with correct parity leaves `err_n` high whatever those inputs hold.
- R9: A cycle that captures no command, because none or several selects are low, raises no parity error even when the parity is wrong.
- R10: A bad-parity command in each of two back-to-back cycles keeps `err_n` low without a gap, for two clocks after the last detection: three low cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quad_n | input | 1 | Strap: 1 = dual duplicated selects, 0 = quad selects |
| cs_n_in | input | 4 | Active-low chip selects (only [1:0] in dual mode) |
| addr_in | input | ADDR_W | Address |
| ba_in | input | BA_W | Bank address |
| ras_n_in | input | 1 | Row strobe |
| cas_n_in | input | 1 | Column strobe |
| we_n_in | input | 1 | Write strobe |
| cke_in | input | CKE_W | Clock enables |
| odt_in | input | ODT_W | Termination controls |
| par_in | input | 1 | Even-parity bit from the controller |
| addr_a | output | ADDR_W | Address, A copy |
| addr_b | output | ADDR_W | Address, B copy |
| ba_a | output | BA_W | Bank, A copy |
| ba_b | output | BA_W | Bank, B copy |
| ras_n_a | output | 1 | Row strobe, A copy |
| ras_n_b | output | 1 | Row strobe, B copy |
| cas_n_a | output | 1 | Column strobe, A copy |
| cas_n_b | output | 1 | Column strobe, B copy |
| we_n_a | output | 1 | Write strobe, A copy |
| we_n_b | output | 1 | Write strobe, B copy |
| cs_out_n | output | 4 | Chip-select outputs (mapping per R4/R5) |
| cke_a | output | CKE_W | Clock enables, A copy |
| cke_b | output | CKE_W | Clock enables, B copy |
| odt_a | output | ODT_W | Termination, A copy |
| odt_b | output | ODT_W | Termination, B copy |
| err_n | output | 1 | Parity error, low while the line is pulled; 1 = released |

## Verification
A new command capture and the stretched error from the previous command can fall in the same cycle. So can a reload of the error stretch and the tail of an earlier error. The bench provokes both by sending bad-parity commands in consecutive cycles and by following a bad command at once with a valid or a rejected one. Each cycle it compares the captured outputs and the error level against a model that carries a one-cycle-delayed detection flag and a two-clock stretch counter. A separate run of bad-parity cycles with several selects low confirms that a rejected capture neither updates the outputs nor feeds the error path.

// File: rtl/cmd_reg_parity.sv
module cmd_reg_parity #(
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3,
  parameter int CKE_W  = 2,
  parameter int ODT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quad_n,
  input  logic [3:0]        cs_n_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BA_W-1:0]   ba_in,
  input  logic              ras_n_in,
  input  logic              cas_n_in,
  input  logic              we_n_in,
  input  logic [CKE_W-1:0]  cke_in,
  input  logic [ODT_W-1:0]  odt_in,
  input  logic              par_in,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output logic [BA_W-1:0]   ba_a,
  output logic [BA_W-1:0]   ba_b,
  output logic              ras_n_a,
  output logic              ras_n_b,
  output logic              cas_n_a,
  output logic              cas_n_b,
  output logic              we_n_a,
  output logic              we_n_b,
  output logic [3:0]        cs_out_n,
  output logic [CKE_W-1:0]  cke_a,
  output logic [CKE_W-1:0]  cke_b,
  output logic [ODT_W-1:0]  odt_a,
  output logic [ODT_W-1:0]  odt_b,
  output logic              err_n
);
  localparam int CMD_W = ADDR_W + BA_W + 3;
  localparam logic [CMD_W-1:0] CMD_RST = {{(ADDR_W+BA_W){1'b0}}, 3'b111};

  logic [3:0]       cs_active_n;
  logic             one_sel;
  logic [CMD_W-1:0] cmd_d;
  logic [CMD_W-1:0] cmd_q [2];
  logic [CKE_W-1:0] cke_q [2];
  logic [ODT_W-1:0] odt_q [2];
  logic [3:0]       cs_q;
  logic             cap_q;
  logic             par_q;
  logic [1:0]       err_cnt;
  logic             par_bad;

  assign cs_active_n = quad_n ? {2'b11, cs_n_in[1:0]} : cs_n_in;
  assign one_sel     = ($countones(~cs_active_n) == 1);
  assign cmd_d       = {addr_in, ba_in, ras_n_in, cas_n_in, we_n_in};

  for (genvar g = 0; g < 2; g++) begin : gen_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q[g] <= CMD_RST;
        cke_q[g] <= '0;
        odt_q[g] <= '0;
      end else begin
        if (one_sel) cmd_q[g] <= cmd_d;
        cke_q[g] <= cke_in;
        odt_q[g] <= odt_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 4'hF;
      cap_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      cs_q  <= quad_n ? {cs_n_in[1:0], cs_n_in[1:0]} : cs_n_in;
      cap_q <= one_sel;
      if (one_sel) par_q <= par_in;
    end
  end

  assign par_bad = cap_q & (^{cmd_q[0], par_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             err_cnt <= '0;
    else if (par_bad)       err_cnt <= 2'd2;
    else if (err_cnt != '0) err_cnt <= err_cnt - 2'd1;
  end

  assign err_n = (err_cnt == '0);

  assign {addr_a, ba_a, ras_n_a, cas_n_a, we_n_a} = cmd_q[0];
  assign {addr_b, ba_b, ras_n_b, cas_n_b, we_n_b} = cmd_q[1];
  assign cs_out_n = cs_q;
  assign cke_a    = cke_q[0];
  assign cke_b    = cke_q[1];
  assign odt_a    = odt_q[0];
  assign odt_b    = odt_q[1];
endmodule

module cmd_reg_parity_chk #(
  parameter int ADDR_W = 16,
  parameter int BA_W   = 3,
  parameter int CKE_W  = 2,
  parameter int ODT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              quad_n,
  input logic [3:0]        cs_n_in,
  input logic [ADDR_W-1:0] addr_in,
  input logic [CKE_W-1:0]  cke_in,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [3:0]        cs_out_n,
  input logic [CKE_W-1:0]  cke_a,
  input logic [CKE_W-1:0]  cke_b,
  input logic              err_n
);
  logic [3:0] sel_n;
  logic       single;
  assign sel_n  = quad_n ? {2'b11, cs_n_in[1:0]} : cs_n_in;
  assign single = ($countones(~sel_n) == 1);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    single |=> (addr_a == $past(addr_in)) && (addr_b == $past(addr_in)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !single |=> $stable(addr_a) && $stable(addr_b));

  p_dual_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quad_n |=> cs_out_n == {$past(cs_n_in[1:0]), $past(cs_n_in[1:0])});

  p_quad_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !quad_n |=> cs_out_n == $past(cs_n_in));

  p_cke_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_a == $past(cke_in)) && (cke_b == $past(cke_in)));

  p_err_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |=> !err_n);
endmodule

bind cmd_reg_parity cmd_reg_parity_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .CKE_W(CKE_W), .ODT_W(ODT_W)
) u_chk (.*);

// File: tb/sim_cmd_reg_parity.sv
`timescale 1ns/1ps
module sim_cmd_reg_parity;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        quad_n = 1'b1;
  logic [3:0]  cs_n_in = 4'hF;
  logic [15:0] addr_in = '0;
  logic [2:0]  ba_in = '0;
  logic        ras_n_in = 1'b1, cas_n_in = 1'b1, we_n_in = 1'b1;
  logic [1:0]  cke_in = '0, odt_in = '0;
  logic        par_in = 1'b0;
  logic [15:0] addr_a, addr_b;
  logic [2:0]  ba_a, ba_b;
  logic        ras_n_a, ras_n_b, cas_n_a, cas_n_b, we_n_a, we_n_b;
  logic [3:0]  cs_out_n;
  logic [1:0]  cke_a, cke_b, odt_a, odt_b;
  logic        err_n;

  cmd_reg_parity u0 (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic       quad_n;
    logic [3:0] cs;
    logic [15:0] addr;
    logic [2:0] ba;
    logic [2:0] cmd;
    logic [1:0] cke;
    logic [1:0] odt;
    logic       bad;
    logic       load;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'b1110, 16'h1234, 3'd2, 3'b011, 2'b11, 2'b01, 1'b0, 1'b1},
    '{1'b1, 4'b0001, 16'hA5F0, 3'd5, 3'b101, 2'b10, 2'b10, 1'b1, 1'b1},
    '{1'b1, 4'b1100, 16'hFFFF, 3'd7, 3'b000, 2'b01, 2'b11, 1'b1, 1'b0},
    '{1'b1, 4'b0011, 16'h0F0F, 3'd1, 3'b110, 2'b00, 2'b00, 1'b0, 1'b0},
    '{1'b0, 4'b1011, 16'h8001, 3'd3, 3'b010, 2'b11, 2'b11, 1'b0, 1'b1},
    '{1'b0, 4'b0011, 16'h7777, 3'd6, 3'b111, 2'b01, 2'b00, 1'b0, 1'b0},
    '{1'b0, 4'b0111, 16'h0003, 3'd0, 3'b001, 2'b10, 2'b01, 1'b1, 1'b1},
    '{1'b0, 4'b1110, 16'hC0DE, 3'd4, 3'b100, 2'b11, 2'b10, 1'b1, 1'b1},
    '{1'b0, 4'b1111, 16'h5555, 3'd2, 3'b000, 2'b00, 2'b11, 1'b0, 1'b0},
    '{1'b1, 4'b1101, 16'h00FF, 3'd1, 3'b011, 2'b01, 2'b01, 1'b0, 1'b1},
    '{1'b0, 4'b1101, 16'h3C3C, 3'd5, 3'b101, 2'b10, 2'b00, 1'b0, 1'b1},
    '{1'b0, 4'b0000, 16'h9999, 3'd7, 3'b111, 2'b11, 2'b11, 1'b1, 1'b0}
  };

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  logic [15:0] m_addr = '0;
  logic [2:0]  m_ba = '0;
  logic [2:0]  m_cmd = 3'b111;
  int          m_cnt = 0;
  logic        m_pend = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v, input string etag);
    logic [3:0] exp_cs;
    quad_n   = v.quad_n;
    cs_n_in  = v.cs;
    addr_in  = v.addr;
    ba_in    = v.ba;
    {ras_n_in, cas_n_in, we_n_in} = v.cmd;
    cke_in   = v.cke;
    odt_in   = v.odt;
    par_in   = (^{v.addr, v.ba, v.cmd}) ^ v.bad;
    @(negedge clk);
    if (v.load) begin
      m_addr = v.addr; m_ba = v.ba; m_cmd = v.cmd;
    end
    m_cnt  = m_pend ? 2 : (m_cnt > 0 ? m_cnt - 1 : 0);
    m_pend = v.load & v.bad;
    exp_cs = v.quad_n ? {v.cs[1:0], v.cs[1:0]} : v.cs;
    chk(addr_a == m_addr, v.load ? "R2" : "R3", "addr_a", 32'(addr_a), 32'(m_addr));
    chk(addr_b == m_addr, v.load ? "R2" : "R3", "addr_b", 32'(addr_b), 32'(m_addr));
    chk(ba_a == m_ba && ba_b == m_ba, v.load ? "R2" : "R3", "bank",
        32'({ba_a, ba_b}), 32'({m_ba, m_ba}));
    chk({ras_n_a, cas_n_a, we_n_a} == m_cmd && {ras_n_b, cas_n_b, we_n_b} == m_cmd,
        v.load ? "R2" : "R3", "strobes",
        32'({ras_n_a, cas_n_a, we_n_a, ras_n_b, cas_n_b, we_n_b}), 32'({m_cmd, m_cmd}));
    chk(cs_out_n == exp_cs, v.quad_n ? "R4" : "R5", "cs_out_n", 32'(cs_out_n), 32'(exp_cs));
    chk(cke_a == v.cke && cke_b == v.cke && odt_a == v.odt && odt_b == v.odt,
        "R6", "cke/odt", 32'({cke_a, cke_b, odt_a, odt_b}), 32'({v.cke, v.cke, v.odt, v.odt}));
    chk(err_n == (m_cnt == 0), etag, "err_n", 32'(err_n), 32'(m_cnt == 0));
  endtask

  function automatic vec_t idle(input logic q);
    return '{q, 4'b1111, 16'h0000, 3'd0, 3'b111, 2'b00, 2'b00, 1'b0, 1'b0};
  endfunction

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    chk(cs_out_n == 4'hF && cke_a == 0 && cke_b == 0 && odt_a == 0 && odt_b == 0,
        "R1", "reset selects/cke/odt", 32'({cs_out_n, cke_a, cke_b, odt_a, odt_b}), 32'hF00);
    chk(addr_a == 0 && addr_b == 0 && ba_a == 0 && {ras_n_a, cas_n_a, we_n_a} == 3'b111,
        "R1", "reset addr/strobes", 32'({addr_a, ras_n_a, cas_n_a, we_n_a}), 32'h7);
    chk(err_n == 1'b1, "R1", "reset err_n", 32'(err_n), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(TBL[i], "R7");
    repeat (3) step(idle(1'b0), "R7");

    // R8: good parity with busy rank-dependent inputs
    step('{1'b0, 4'b1110, 16'hF00D, 3'd6, 3'b010, 2'b11, 2'b11, 1'b0, 1'b1}, "R8");
    step('{1'b0, 4'b0111, 16'hF00D, 3'd6, 3'b010, 2'b01, 2'b10, 1'b0, 1'b1}, "R8");
    repeat (2) step(idle(1'b0), "R8");

    // R9: bad parity on rejected cycles
    step('{1'b0, 4'b0110, 16'h1357, 3'd1, 3'b001, 2'b10, 2'b10, 1'b1, 1'b0}, "R9");
    step('{1'b1, 4'b1100, 16'h2468, 3'd2, 3'b100, 2'b01, 2'b01, 1'b1, 1'b0}, "R9");
    repeat (2) step(idle(1'b1), "R9");

    // R10: back-to-back bad commands, count low cycles
    lows = 0;
    step('{1'b0, 4'b1110, 16'h0101, 3'd3, 3'b110, 2'b00, 2'b00, 1'b1, 1'b1}, "R10");
    if (!err_n) lows++;
    step('{1'b0, 4'b1011, 16'h0202, 3'd4, 3'b011, 2'b00, 2'b00, 1'b1, 1'b1}, "R10");
    if (!err_n) lows++;
    for (int k = 0; k < 5; k++) begin
      step(idle(1'b0), "R10");
      if (!err_n) lows++;
    end
    chk(lows == 3, "R10", "low cycle count", 32'(lows), 32'd3);

    // R1: asynchronous reset mid-run with loaded outputs and a pending error
    step('{1'b0, 4'b1101, 16'hBEEF, 3'd5, 3'b000, 2'b11, 2'b11, 1'b1, 1'b1}, "R7");
    step(idle(1'b0), "R7");
    #1 rst_n = 1'b0;
    #1;
    chk(cs_out_n == 4'hF && cke_a == 0 && odt_b == 0, "R1", "async reset selects",
        32'({cs_out_n, cke_a, odt_b}), 32'hF0);
    chk(addr_a == 0 && addr_b == 0 && {ras_n_b, cas_n_b, we_n_b} == 3'b111, "R1",
        "async reset addr", 32'(addr_a), 32'd0);
    chk(err_n == 1'b1, "R1", "async reset err_n", 32'(err_n), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule